// File: doc/BRIEF.md
# Multi-Source Prescaled IRQ Counter

This block is an interrupt timer for a cartridge controller. An 8-bit event counter sits behind an 8-bit prescaler. The prescaler advances once per clocking event, and the counter steps each time the prescaler wraps. The counter can run upward or downward, or it can be held still. The prescaler can be narrowed so that only its low bits wrap, which gives a short period. Four event strobes can drive the timer, and the control register picks one of them:

- a CPU cycle strobe
- a PPU A12 rise strobe
- a PPU address strobe that carries the address
- a CPU write strobe

Each strobe is a single-cycle pulse. The logic that produces these pulses from the real buses lives elsewhere.

Software sets the timer up with byte writes to eight register slots, selected by a 3-bit select. The slots turn the timer on and off, set the control byte, and load the prescaler and the counter. A key register is XORed into every loaded value. The interrupt output is a level. It rises on the terminal count and stays high until software writes one of the two disable slots.

Top module: `irqtmr_top`

## Requirements
- R1: After reset the interrupt is low, the timer is off, and the control byte, key, prescaler, counter and latched PPU address are all zero.
- R2: A write to slot 6 stores the key. A write to slot 4 loads the prescaler with data XOR key. A write to slot 5 loads the counter with data XOR key.
- R3: Control bits [7:6] = 01 count up. Each clocking event adds one to the active prescaler bits. When those bits wrap to zero, the counter increments. If the counter is then 0x00, the interrupt is raised.
- R4: Control bits [7:6] = 10 count down. Each event subtracts one from the active prescaler bits. When those bits wrap to all ones, the counter decrements. If the counter is then 0xFF, the interrupt is raised.
- R5: Control bits [7:6] = 00 or 11 leave the counter unchanged and never raise the interrupt.
- R6: With control bit 3 set, the counter does not step. Its present value is still tested against the terminal value each time the prescaler wraps.
- R7: With control bit 2 set, only prescaler bits [2:0] step and wrap. Bits [7:3] keep their value.
- R8: Control bits [1:0] select the clocking source: 0 is the CPU cycle strobe, 1 is the A12 rise strobe and 3 is the CPU write strobe. Strobes from sources that are not selected have no effect.
- R9: With source 2, a PPU address strobe whose address differs from the last latched address gives two clocking events. A strobe that repeats the latched address gives none. Every PPU address strobe latches its address, whatever source is selected.
- R10: While the timer is off, no clocking happens. Slot 3 turns the timer on. Slot 0 turns it on when data bit 0 is 1 and off when data bit 0 is 0.
- R11: Once raised, the interrupt stays high until a slot 2 write or a slot 0 write with bit 0 clear. Each of these writes also turns the timer off and zeroes the prescaler. Slot 3 does not lower the interrupt.
- R12: In a cycle that both clocks the timer and writes a register, the clocking uses the state from before the write. Any field the write loads then overrides the clocked result. A clearing write wins over a terminal count raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register slot select |
| wrData | input | DATA_W | Write data |
| cpuCycleStb | input | 1 | CPU cycle event pulse |
| ppuA12RiseStb | input | 1 | PPU A12 rising-edge event pulse |
| ppuAddrStb | input | 1 | PPU address event pulse |
| ppuAddr | input | ADDR_W | PPU address sampled with ppuAddrStb |
| cpuWriteStb | input | 1 | CPU write event pulse |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bench uses the default parameters: an 8-bit prescaler and counter, a 3-bit narrow window and a 14-bit PPU address. With these values a full 256-event wide prescaler wrap is short enough to run to completion, so both the narrow and wide terminal counts are hit exactly. Each of the eight register slots can be reached with random data. Random PPU addresses are drawn from a small set, so repeated addresses and changed addresses both occur often.

// File: rtl/irqtmr_pkg.sv
package irqtmr_pkg;

  localparam int STEP_W       = 2;
  localparam int ADDR_CHG_EVT = 2;

  typedef enum logic [2:0] {
    SEL_EN_BIT = 3'd0,
    SEL_CTRL   = 3'd1,
    SEL_OFF    = 3'd2,
    SEL_ON     = 3'd3,
    SEL_PRE    = 3'd4,
    SEL_CNT    = 3'd5,
    SEL_KEY    = 3'd6,
    SEL_NONE   = 3'd7
  } regSel_e;

  typedef enum logic [1:0] {
    SRC_CPU_CYC  = 2'd0,
    SRC_A12      = 2'd1,
    SRC_ADDR_CHG = 2'd2,
    SRC_CPU_WR   = 2'd3
  } clkSrc_e;

  typedef enum logic [1:0] {
    DIR_HOLD_LO = 2'd0,
    DIR_UP      = 2'd1,
    DIR_DOWN    = 2'd2,
    DIR_HOLD_HI = 2'd3
  } dir_e;

  // Strobes from control to datapath for one clock
  typedef struct packed {
    logic [STEP_W-1:0] stepCnt;
    logic              up;
    logic              down;
    logic              narrow;
    logic              freeze;
    logic              loadPre;
    logic              loadCnt;
    logic              clrPre;
  } tmrCmd_t;

endpackage

// File: rtl/irqtmr_dp.sv
module irqtmr_dp
  import irqtmr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NARROW_W  = 3,
  parameter int MAX_STEPS = ADDR_CHG_EVT
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrCmd_t           cmd,
  input  logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] preQ,
  output logic [DATA_W-1:0] cntQ,
  output logic              wrapHit
);

  localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'((1 << NARROW_W) - 1);
  localparam logic [DATA_W-1:0] ALL_ONES    = {DATA_W{1'b1}};

  logic [DATA_W-1:0] preMask;
  logic [DATA_W-1:0] preChain [0:MAX_STEPS];
  logic [DATA_W-1:0] cntChain [0:MAX_STEPS];
  logic [MAX_STEPS-1:0] hitVec;

  assign preMask     = cmd.narrow ? NARROW_MASK : ALL_ONES;
  assign preChain[0] = preQ;
  assign cntChain[0] = cntQ;

  // One clocking event per stage; stages beyond stepCnt pass through
  for (genvar k = 0; k < MAX_STEPS; k++) begin : g_stage
    logic              active;
    logic [DATA_W-1:0] lowNext;
    logic [DATA_W-1:0] cntStep;
    logic [DATA_W-1:0] preOut;
    logic [DATA_W-1:0] cntOut;
    logic              hitOut;

    assign active = (32'(cmd.stepCnt) > k);

    always_comb begin
      preOut  = preChain[k];
      cntOut  = cntChain[k];
      hitOut  = 1'b0;
      lowNext = '0;
      cntStep = cntChain[k];
      if (active && cmd.up) begin
        lowNext = (preChain[k] + 1'b1) & preMask;
        preOut  = (preChain[k] & ~preMask) | lowNext;
        if (lowNext == '0) begin
          cntStep = cmd.freeze ? cntChain[k] : cntChain[k] + 1'b1;
          cntOut  = cntStep;
          hitOut  = (cntStep == '0);
        end
      end else if (active && cmd.down) begin
        lowNext = (preChain[k] - 1'b1) & preMask;
        preOut  = (preChain[k] & ~preMask) | lowNext;
        if (lowNext == preMask) begin
          cntStep = cmd.freeze ? cntChain[k] : cntChain[k] - 1'b1;
          cntOut  = cntStep;
          hitOut  = (cntStep == ALL_ONES);
        end
      end
    end

    assign preChain[k+1] = preOut;
    assign cntChain[k+1] = cntOut;
    assign hitVec[k]     = hitOut;
  end

  assign wrapHit = |hitVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ <= '0;
      cntQ <= '0;
    end else begin
      if (cmd.clrPre)       preQ <= '0;
      else if (cmd.loadPre) preQ <= loadVal;
      else                  preQ <= preChain[MAX_STEPS];
      if (cmd.loadCnt)      cntQ <= loadVal;
      else                  cntQ <= cntChain[MAX_STEPS];
    end
  end

endmodule

// File: rtl/irqtmr_ctrl.sv
module irqtmr_ctrl
  import irqtmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cpuCycleStb,
  input  logic              ppuA12RiseStb,
  input  logic              ppuAddrStb,
  input  logic [ADDR_W-1:0] ppuAddr,
  input  logic              cpuWriteStb,
  input  logic              wrapHit,
  output tmrCmd_t           cmd,
  output logic [DATA_W-1:0] loadVal,
  output logic              irqOut,
  output logic              enQ,
  output logic [7:0]        ctrlQ
);

  logic [DATA_W-1:0] keyQ;
  logic [ADDR_W-1:0] lastAddrQ;
  logic              irqQ;
  logic [STEP_W-1:0] rawSteps;
  regSel_e           sel;
  dir_e              dir;
  logic              clrWr;

  assign sel = regSel_e'(wrSel);
  assign dir = dir_e'(ctrlQ[7:6]);

  always_comb begin
    case (clkSrc_e'(ctrlQ[1:0]))
      SRC_CPU_CYC:  rawSteps = STEP_W'(cpuCycleStb);
      SRC_A12:      rawSteps = STEP_W'(ppuA12RiseStb);
      SRC_ADDR_CHG: rawSteps = (ppuAddrStb && (ppuAddr != lastAddrQ))
                               ? STEP_W'(ADDR_CHG_EVT) : '0;
      default:      rawSteps = STEP_W'(cpuWriteStb);
    endcase
  end

  assign clrWr = wrEn && ((sel == SEL_OFF) || ((sel == SEL_EN_BIT) && !wrData[0]));

  always_comb begin
    cmd.stepCnt = enQ ? rawSteps : '0;
    cmd.up      = (dir == DIR_UP);
    cmd.down    = (dir == DIR_DOWN);
    cmd.narrow  = ctrlQ[2];
    cmd.freeze  = ctrlQ[3];
    cmd.loadPre = wrEn && (sel == SEL_PRE);
    cmd.loadCnt = wrEn && (sel == SEL_CNT);
    cmd.clrPre  = clrWr;
  end

  assign loadVal = wrData ^ keyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ       <= 1'b0;
      ctrlQ     <= '0;
      keyQ      <= '0;
      lastAddrQ <= '0;
      irqQ      <= 1'b0;
    end else begin
      if (ppuAddrStb) lastAddrQ <= ppuAddr;
      if (clrWr)        irqQ <= 1'b0;
      else if (wrapHit) irqQ <= 1'b1;
      if (wrEn) begin
        case (sel)
          SEL_EN_BIT: enQ   <= wrData[0];
          SEL_CTRL:   ctrlQ <= wrData[7:0];
          SEL_OFF:    enQ   <= 1'b0;
          SEL_ON:     enQ   <= 1'b1;
          SEL_KEY:    keyQ  <= wrData;
          default:    ;
        endcase
      end
    end
  end

  assign irqOut = irqQ;

endmodule

// File: rtl/irqtmr_top.sv
module irqtmr_top
  import irqtmr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NARROW_W = 3,
  parameter int ADDR_W   = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cpuCycleStb,
  input  logic              ppuA12RiseStb,
  input  logic              ppuAddrStb,
  input  logic [ADDR_W-1:0] ppuAddr,
  input  logic              cpuWriteStb,
  output logic              irqOut
);

  tmrCmd_t           cmd;
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] preQ;
  logic [DATA_W-1:0] cntQ;
  logic              wrapHit;
  logic              enQ;
  logic [7:0]        ctrlQ;

  irqtmr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .cpuCycleStb(cpuCycleStb), .ppuA12RiseStb(ppuA12RiseStb),
    .ppuAddrStb(ppuAddrStb), .ppuAddr(ppuAddr), .cpuWriteStb(cpuWriteStb),
    .wrapHit(wrapHit), .cmd(cmd), .loadVal(loadVal), .irqOut(irqOut),
    .enQ(enQ), .ctrlQ(ctrlQ)
  );

  irqtmr_dp #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .MAX_STEPS(ADDR_CHG_EVT)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .loadVal(loadVal),
    .preQ(preQ), .cntQ(cntQ), .wrapHit(wrapHit)
  );

endmodule

// File: rtl/irqtmr_chk.sv
module irqtmr_chk #(
  parameter int DATA_W   = 8,
  parameter int NARROW_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [2:0]        wrSel,
  input logic [DATA_W-1:0] wrData,
  input logic              irqOut,
  input logic              enQ,
  input logic [7:0]        ctrlQ,
  input logic [DATA_W-1:0] preQ,
  input logic [DATA_W-1:0] cntQ
);

  logic clrWr, cntWr, preWr;
  assign clrWr = wrEn && ((wrSel == 3'd2) || ((wrSel == 3'd0) && !wrData[0]));
  assign cntWr = wrEn && (wrSel == 3'd5);
  assign preWr = wrEn && (wrSel == 3'd4);

  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqOut && !clrWr |=> irqOut);

  p_irq_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> !irqOut && (preQ == '0) && !enQ);

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enQ && !irqOut |=> !irqOut);

  p_hold_dir_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrlQ[7:6] == 2'b00) || (ctrlQ[7:6] == 2'b11)) && !cntWr |=> $stable(cntQ));

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[3] && !cntWr |=> $stable(cntQ));

  p_narrow_upper_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[2] && !preWr && !clrWr |=> $stable(preQ[DATA_W-1:NARROW_W]));

endmodule

bind irqtmr_top irqtmr_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .irqOut(irqOut), .enQ(enQ), .ctrlQ(ctrlQ), .preQ(preQ), .cntQ(cntQ)
);

// File: tb/irqtmr_top_tb_top.sv
`timescale 1ns/1ps
module irqtmr_top_tb_top;

  localparam int DW = 8;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrSel = '0;
  logic [DW-1:0] wrData = '0;
  logic          cpuCycleStb = 1'b0, ppuA12RiseStb = 1'b0, ppuAddrStb = 1'b0, cpuWriteStb = 1'b0;
  logic [AW-1:0] ppuAddr = '0;
  logic          irqOut;

  int nChecks = 0;
  int nFails  = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  irqtmr_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .cpuCycleStb(cpuCycleStb), .ppuA12RiseStb(ppuA12RiseStb),
    .ppuAddrStb(ppuAddrStb), .ppuAddr(ppuAddr), .cpuWriteStb(cpuWriteStb),
    .irqOut(irqOut)
  );

  // Behavioural reference
  int mPre, mCnt, mCtl, mKey, mLast, mEn, mIrq;

  task automatic modelStep();
    int mask, low;
    mask = ((mCtl >> 2) & 1) ? 7 : 255;
    if (((mCtl >> 6) & 3) == 1) begin
      low = (mPre + 1) & mask;
      mPre = ((mPre & ~mask) | low) & 255;
      if (low == 0) begin
        if (((mCtl >> 3) & 1) == 0) mCnt = (mCnt + 1) & 255;
        if (mCnt == 0) mIrq = 1;
      end
    end else if (((mCtl >> 6) & 3) == 2) begin
      low = (mPre - 1) & mask;
      mPre = ((mPre & ~mask) | low) & 255;
      if (low == mask) begin
        if (((mCtl >> 3) & 1) == 0) mCnt = (mCnt - 1) & 255;
        if (mCnt == 255) mIrq = 1;
      end
    end
  endtask

  always @(posedge clk) begin
    int n;
    if (!rstN) begin
      mPre = 0; mCnt = 0; mCtl = 0; mKey = 0; mLast = 0; mEn = 0; mIrq = 0;
    end else begin
      case (mCtl & 3)
        0: n = int'(cpuCycleStb);
        1: n = int'(ppuA12RiseStb);
        2: n = (ppuAddrStb && (int'(ppuAddr) != mLast)) ? 2 : 0;
        default: n = int'(cpuWriteStb);
      endcase
      if (ppuAddrStb) mLast = int'(ppuAddr);
      if (mEn != 0) for (int i = 0; i < n; i++) modelStep();
      if (wrEn) begin
        case (wrSel)
          3'd0: begin mEn = int'(wrData[0]); if (!wrData[0]) begin mPre = 0; mIrq = 0; end end
          3'd1: mCtl = int'(wrData);
          3'd2: begin mEn = 0; mPre = 0; mIrq = 0; end
          3'd3: mEn = 1;
          3'd4: mPre = int'(wrData) ^ mKey;
          3'd5: mCnt = int'(wrData) ^ mKey;
          3'd6: mKey = int'(wrData);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done)
      chk(irqOut == mIrq[0], {phase, " model"}, int'(irqOut), mIrq);
  end

  task automatic cyc(input bit we, input int sel, input int data,
                     input bit cc, input bit a12, input bit as, input int addr, input bit cw);
    wrEn = we; wrSel = 3'(sel); wrData = DW'(data);
    cpuCycleStb = cc; ppuA12RiseStb = a12; ppuAddrStb = as; ppuAddr = AW'(addr); cpuWriteStb = cw;
    @(negedge clk);
    wrEn = 1'b0; cpuCycleStb = 1'b0; ppuA12RiseStb = 1'b0; ppuAddrStb = 1'b0; cpuWriteStb = 1'b0;
  endtask

  task automatic wr(input int sel, input int data);
    cyc(1'b1, sel, data, 1'b0, 1'b0, 1'b0, 0, 1'b0);
  endtask

  task automatic cpuTicks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 1'b1, 1'b0, 1'b0, 0, 1'b0);
  endtask

  task automatic expIrq(input int e, input string req);
    chk(irqOut == e[0], req, int'(irqOut), e);
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expIrq(0, "R1 reset irq");
    // R1: down narrow from zeroed state hits 0xFF on first event
    wr(3, 0); wr(1, 8'h84);
    cpuTicks(1); expIrq(1, "R1 zero counter/prescaler");

    phase = "R11";
    wr(3, 0);    expIrq(1, "R11 slot3 keeps irq");
    wr(0, 1);    expIrq(1, "R11 slot0 bit0=1 keeps irq");
    wr(2, 0);    expIrq(0, "R11 slot2 drops irq");

    phase = "R3";
    wr(5, 8'hFE); wr(4, 0); wr(1, 8'h44); wr(3, 0);
    cpuTicks(15); expIrq(0, "R3 before up terminal");
    cpuTicks(1);  expIrq(1, "R3 up terminal");
    wr(0, 0);     expIrq(0, "R11 slot0 bit0=0 drops irq");

    phase = "R2";
    wr(6, 8'h5A); wr(5, 8'hA5); wr(4, 8'h5A ^ 8'h06); wr(1, 8'h44); wr(3, 0);
    cpuTicks(1); expIrq(0, "R2 keyed prescaler 7");
    cpuTicks(1); expIrq(1, "R2 keyed counter FF wraps");
    wr(2, 0); wr(6, 0);

    phase = "R4";
    wr(5, 1); wr(4, 2); wr(1, 8'h80); wr(3, 0);
    cpuTicks(3);   expIrq(0, "R4 counter to zero");
    cpuTicks(255); expIrq(0, "R4 before down terminal");
    cpuTicks(1);   expIrq(1, "R4 down terminal");
    wr(2, 0);

    phase = "R5";
    wr(5, 8'hFF); wr(1, 8'h04); wr(3, 0);
    cpuTicks(20); expIrq(0, "R5 dir 00 holds");
    wr(1, 8'hC4); cpuTicks(20); expIrq(0, "R5 dir 11 holds");
    wr(1, 8'h44); cpuTicks(8);  expIrq(1, "R5 counter kept FF");
    wr(2, 0);

    phase = "R6";
    wr(5, 0); wr(1, 8'h4C); wr(3, 0);
    cpuTicks(7); expIrq(0, "R6 freeze before wrap");
    cpuTicks(1); expIrq(1, "R6 frozen zero tested");
    wr(2, 0);

    phase = "R7";
    wr(5, 8'hFF); wr(4, 8'hA0); wr(1, 8'h44); wr(3, 0);
    cpuTicks(7); expIrq(0, "R7 narrow before wrap");
    cpuTicks(1); expIrq(1, "R7 narrow wrap at 8");
    wr(2, 0);

    phase = "R8";
    wr(5, 8'hFF); wr(1, 8'h45); wr(3, 0);
    for (int i = 0; i < 8; i++) cyc(1'b0, 0, 0, 1'b1, 1'b0, 1'b1, 0, 1'b1);
    expIrq(0, "R8 unselected strobes ignored");
    for (int i = 0; i < 8; i++) cyc(1'b0, 0, 0, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    expIrq(1, "R8 A12 source");
    wr(2, 0); wr(5, 8'hFF); wr(1, 8'h47); wr(3, 0);
    for (int i = 0; i < 8; i++) cyc(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b1);
    expIrq(1, "R8 CPU write source");
    wr(2, 0);

    phase = "R9";
    wr(5, 8'hFF); wr(1, 8'h46); wr(3, 0);
    for (int i = 0; i < 3; i++) cyc(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, 0, 1'b0);
    cyc(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, 1, 1'b0);
    cyc(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, 2, 1'b0);
    cyc(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, 1, 1'b0);
    expIrq(0, "R9 six events");
    cyc(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, 2, 1'b0);
    expIrq(1, "R9 eight events");
    wr(2, 0);

    phase = "R10";
    wr(5, 8'hFF); wr(1, 8'h44);
    cpuTicks(20); expIrq(0, "R10 off no clocking");
    wr(0, 1); cpuTicks(8); expIrq(1, "R10 slot0 enable");
    wr(2, 0);

    phase = "R12";
    wr(5, 8'hFF); wr(4, 8'h07); wr(1, 8'h47); wr(3, 0);
    cyc(1'b1, 5, 8'h10, 1'b0, 1'b0, 1'b0, 0, 1'b1);
    expIrq(1, "R12 step uses old counter");
    wr(2, 0); wr(5, 8'hFF); wr(4, 8'h07); wr(3, 0);
    cyc(1'b1, 2, 0, 1'b0, 1'b0, 1'b0, 0, 1'b1);
    expIrq(0, "R12 clear wins");

    phase = "R12 random";
    for (int i = 0; i < 4000; i++) begin
      automatic int r = int'($urandom);
      cyc((r & 7) == 0, (r >> 3) & 7, (r >> 6) & 255, r[14], r[15], r[16], (r >> 17) & 3, r[19]);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule